// File: doc/BRIEF.md
# Bit-Serial Character Transmitter

This block takes one character from a parallel bus and sends it out on a single wire, one bit per clock cycle, with no rate divider. Each frame begins with a low start bit. The data bits follow, lowest bit first, and a high stop bit closes the frame. A one-cycle strobe starts a frame. The character is copied into an internal register on that strobe, so the bus is free for the rest of the frame. When the frame is complete, a one-cycle completion pulse appears. The block accepts a new strobe in that same cycle, so frames can be sent back to back without a gap.

Internally the block is split into a datapath and a controller. The datapath holds a loadable shift register, a bit-index counter and the output selector. The controller is a five-state machine: idle, start, data, stop and done. The character width is a parameter, with a default of 8.

Top module: `char_serializer`

## Requirements
- R1: After reset, and whenever no frame is in progress, the serial output is 1 and the done output is 0.
- R2: When start is sampled high in the idle state, the serial output is 0 (the start bit) during the next clock cycle.
- R3: In the eight cycles after the start bit, the serial output carries data bit 0, then bit 1, and so on up to bit 7, one bit per cycle.
- R4: In the cycle after data bit 7, the serial output is 1 (the stop bit) and done is still 0.
- R5: Done is high for exactly one cycle, the cycle after the stop bit. That is the 11th cycle after the edge that sampled start. The serial output stays 1 during that cycle, and done is 0 at every other time.
- R6: The character is captured on the edge that accepts start. Changes on the data bus during a frame do not alter the bits sent.
- R7: A start strobe sampled during the start, data or stop cycles of a frame is ignored. The frame in progress continues unchanged, and no extra frame follows it.
- R8: A start strobe sampled in the done cycle is accepted. The start bit of the new frame appears in the very next cycle.
- R9: A synchronous reset sampled at any point of a frame abandons it. From the next cycle the serial output is 1 and done is 0, and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle strobe marking a new character on data_i |
| data_i | input | DATA_W (8) | Character to send |
| sdata_o | output | 1 | Serial data line |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions assume that reset is held high at the first clock edge. They also assume that start_i and data_i are known values at every sampling edge. Apart from that they accept any start pattern, including strobes in the middle of a frame. The stimulus drives every input on the falling edge, away from the sampling edge, and asserts reset from time zero. It sends random characters with random frame-to-frame chaining. In random frames it scrambles the bus and fires stray start strobes during the start, data and stop cycles. It also forces a reset in the middle of a frame.

// File: rtl/char_ser_pkg.sv
package char_ser_pkg;
   typedef enum logic [2:0] {
      TX_IDLE  = 3'd0,
      TX_START = 3'd1,
      TX_DATA  = 3'd2,
      TX_STOP  = 3'd3,
      TX_DONE  = 3'd4
   } tx_state_e;

   function automatic logic line_level(input tx_state_e s, input logic data_bit);
      case (s)
         TX_START: line_level = 1'b0;
         TX_DATA:  line_level = data_bit;
         default:  line_level = 1'b1;
      endcase
   endfunction
endpackage

// File: rtl/cs_shreg.sv
module cs_shreg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic         shift_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q;

   generate
      if (W < 2) begin : g_bad_w
         $error("cs_shreg: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)          q <= '0;
      else if (load_i)  q <= d_i;
      else if (shift_i) q <= {1'b1, q[W-1:1]};
   end

   assign q_o = q;
endmodule

// File: rtl/cs_bitcnt.sv
module cs_bitcnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || clr_i) cnt <= '0;
      else if (inc_i)   cnt <= cnt + 1'b1;
   end

   assign cnt_o = cnt;
endmodule

// File: rtl/cs_ctrl.sv
module cs_ctrl
   import char_ser_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      start_i,
   input  logic      last_i,
   output tx_state_e st_o,
   output logic      load_o,
   output logic      shift_o
);
   tx_state_e st, st_nx;
   logic      accept;

   assign accept = start_i && (st == TX_IDLE || st == TX_DONE);

   always_comb begin
      st_nx = st;
      unique case (st)
         TX_IDLE:  if (accept) st_nx = TX_START;
         TX_START: st_nx = TX_DATA;
         TX_DATA:  if (last_i) st_nx = TX_STOP;
         TX_STOP:  st_nx = TX_DONE;
         TX_DONE:  st_nx = accept ? TX_START : TX_IDLE;
         default:  st_nx = TX_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= TX_IDLE;
      else     st <= st_nx;
   end

   assign st_o    = st;
   assign load_o  = accept;
   assign shift_o = (st == TX_DATA);
endmodule

// File: rtl/char_serializer.sv
module char_serializer
   import char_ser_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              sdata_o,
   output logic              done_o
);
   localparam int CNT_W = $clog2(DATA_W) + 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2 || DATA_W > 64) begin : g_bad_width
         $error("char_serializer: DATA_W out of range 2..64");
      end
   endgenerate

   tx_state_e         st;
   logic              load, shift, cnt_last;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sr;

   cs_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .start_i (start_i),
      .last_i  (cnt_last),
      .st_o    (st),
      .load_o  (load),
      .shift_o (shift)
   );

   cs_bitcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr_i (load),
      .inc_i (shift),
      .cnt_o (cnt)
   );

   cs_shreg #(.W(DATA_W)) u_sr (
      .clk     (clk),
      .rst     (rst),
      .load_i  (load),
      .shift_i (shift),
      .d_i     (data_i),
      .q_o     (sr)
   );

   assign cnt_last = (cnt == LAST);
   assign sdata_o  = line_level(st, sr[0]);
   assign done_o   = (st == TX_DONE);
endmodule

// File: rtl/cs_checker.sv
module cs_checker
   import char_ser_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              start_i,
   input logic              sdata_o,
   input logic              done_o,
   input tx_state_e         st,
   input logic [CNT_W-1:0]  cnt,
   input logic [DATA_W-1:0] sr
);
   // R1 and R9: a reset always lands on an idle line
   assert_reset_idle_R9: assert property (@(posedge clk)
      rst |=> (sdata_o && !done_o));

   assert_start_bit_R2: assert property (@(posedge clk) disable iff (rst)
      (st == TX_IDLE && start_i) |=> (!sdata_o && !done_o));

   assert_next_bit_R3: assert property (@(posedge clk) disable iff (rst)
      (st == TX_DATA && cnt != CNT_W'(DATA_W - 1)) |=> (sdata_o == $past(sr[1])));

   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
      cnt <= CNT_W'(DATA_W));

   assert_stop_then_done_R4: assert property (@(posedge clk) disable iff (rst)
      (st == TX_STOP) |-> (sdata_o && !done_o));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   assert_done_line_high_R5: assert property (@(posedge clk) disable iff (rst)
      done_o |-> sdata_o);

   assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (rst)
      (start_i && st == TX_DATA) |=> (st == TX_DATA || st == TX_STOP));

   assert_chain_R8: assert property (@(posedge clk) disable iff (rst)
      (done_o && start_i) |=> (st == TX_START && !sdata_o));
endmodule

bind char_serializer cs_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start_i (start_i),
   .sdata_o (sdata_o),
   .done_o  (done_o),
   .st      (st),
   .cnt     (cnt),
   .sr      (sr)
);

// File: tb/sim_char_serializer.sv
module sim_char_serializer;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start_i = 1'b0;
   logic [7:0] data_i = '0;
   logic       sdata_o, done_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   char_serializer #(.DATA_W(8)) u0 (
      .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i),
      .sdata_o(sdata_o), .done_o(done_o)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         fails = fails + 1;
         $display("FAIL watchdog R5: cycles=%0d expected frames to finish", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // expected line level at position k of a frame: 0 start, 1..8 data, 9 stop
   function automatic logic frame_bit(input logic [7:0] d, input int k);
      if (k == 0)      return 1'b0;
      else if (k == 9) return 1'b1;
      else             return d[k-1];
   endfunction

   task automatic check(input logic act, input logic exp, input string rq, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%b expected=%b", rq, what, act, exp);
      end
   endtask

   // precondition: start_i=1 and data_i=d driven at the current falling edge
   task automatic run_frame(input logic [7:0] d, input bit noise, input string first_rq);
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (k == 0) start_i = 1'b0;
         check(sdata_o, frame_bit(d, k),
               (k == 0) ? first_rq : (k == 9) ? "R4" : (noise ? "R6/R7 R3" : "R3"),
               $sformatf("frame bit %0d", k));
         check(done_o, 1'b0, "R5", $sformatf("done early at bit %0d", k));
         if (noise) begin
            data_i  = 8'($urandom);
            start_i = ($urandom % 3 == 0);
         end
      end
      @(negedge clk);
      start_i = 1'b0;
      check(done_o, 1'b1, "R5", "done after stop");
      check(sdata_o, 1'b1, "R5", "line in done cycle");
   endtask

   initial begin
      logic [7:0] d;
      bit         chain;
      void'($urandom(32'h0051_7E55));
      repeat (3) @(negedge clk);
      check(sdata_o, 1'b1, "R1", "reset line");
      check(done_o, 1'b0, "R1", "reset done");
      rst = 1'b0;
      @(negedge clk);
      check(sdata_o, 1'b1, "R1", "idle line");

      // directed corner patterns
      data_i = 8'h00; start_i = 1'b1; run_frame(8'h00, 1'b0, "R2");
      @(negedge clk); check(done_o, 1'b0, "R5", "done single");
      check(sdata_o, 1'b1, "R1", "idle after frame");
      data_i = 8'hFF; start_i = 1'b1; run_frame(8'hFF, 1'b0, "R2");
      data_i = 8'hA5; start_i = 1'b1; run_frame(8'hA5, 1'b1, "R8");
      data_i = 8'h01; start_i = 1'b1; run_frame(8'h01, 1'b1, "R8");
      @(negedge clk); check(done_o, 1'b0, "R7", "no extra frame done");
      check(sdata_o, 1'b1, "R7", "no extra frame line");
      repeat (3) begin
         @(negedge clk); check(sdata_o, 1'b1, "R1", "idle hold");
      end

      // random frames with random chaining
      chain = 1'b0;
      for (int n = 0; n < 40; n++) begin
         d = 8'($urandom);
         data_i = d; start_i = 1'b1;
         run_frame(d, ($urandom % 2 == 1), chain ? "R8" : "R2");
         chain = ($urandom % 2 == 1);
         if (!chain) begin
            @(negedge clk);
            check(done_o, 1'b0, "R5", "done low after pulse");
            check(sdata_o, 1'b1, "R1", "idle between frames");
         end
      end

      // R9: reset in the middle of a frame
      data_i = 8'h3C; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (4) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(sdata_o, 1'b1, "R9", "line after mid-frame reset");
      check(done_o, 1'b0, "R9", "done after mid-frame reset");
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         check(done_o, 1'b0, "R9", $sformatf("no done after abort, cycle %0d", k));
         check(sdata_o, 1'b1, "R9", $sformatf("line idle after abort, cycle %0d", k));
      end

      // frame after reset still works
      data_i = 8'h96; start_i = 1'b1; run_frame(8'h96, 1'b0, "R2");
      @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule